// File: doc/BRIEF.md
# Decade Counting Stage with Seven-Segment Output

This block is one digit of a decimal counter-display chain. The count is held in a five-bit twisted-ring (Johnson) register that walks through ten states, one for each digit from 0 to 9. Each state decodes straight to seven active-high segment lines, with no binary-coded step in between. A carry line goes through one full period every ten counts, so it can drive the count input of the next, more significant stage. Lamp test forces every segment on. A blanking input/output pair suppresses leading or trailing zeros across a row of digits.

The two count-related pins, count and inhibit, are asynchronous. Each passes through a two-flop synchronizer and an edge detector clocked by the fast system clock, so everything downstream is synchronous.

- A rising count edge advances the digit while inhibit is low.
- With count held high, a falling edge on inhibit advances the digit, so inhibit can serve as a negative-edge count pin.

The state machine has ten named states, D0 to D9. It has four kinds of transition:

- **advance**: Dn to Dn+1, and D9 to D0.
- **hold**: no advance event this cycle.
- **reset**: any state to D0.
- **recover**: any of the 22 unused codes to D0 on the next advance.

Top module: `decade_display`

## Requirements
- R1: The digit cycles through ten states. Ten advance events starting from zero return it to zero.
- R2: While `rst` is high the digit is zero, and reset takes priority over any count event. With `rb_in` high and `lamp_test` low, this shows `seg`=7'h3F, `carry_out`=1 and `rb_out`=1.
- R3: A rising edge on `count_in` while `inhibit_in` is low advances the digit by exactly one.
- R4: While `inhibit_in` is high, edges on `count_in` leave the digit unchanged.
- R5: While `count_in` is held high, a falling edge on `inhibit_in` advances the digit by one. A rising edge on `inhibit_in` and a falling edge on `count_in` do not advance it.
- R6: `carry_out` is 1 for digits 0 to 4 and 0 for digits 5 to 9. It therefore rises as the digit wraps from 9 to 0.
- R7: `seg` bit 0 is segment a and bit 6 is segment g. The digits 0 to 9 show 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R8: While `lamp_test` is high, `seg` is 7'h7F whatever the digit or blanking state. Lamp test does not change the digit.
- R9: When `rb_in` is low and the digit is zero, `seg` is 0 (unless lamp test is on) and `rb_out` is 0. In every other case `rb_out` is 1. Blanking does not change the digit.
- R10: A change on a count pin reaches the outputs on the third rising clock edge after it. A level held for many cycles produces only one advance, and at most one advance happens per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the count pins |
| rst | input | 1 | Active-high reset to digit zero |
| count_in | input | 1 | Asynchronous count pin, rising edge active |
| inhibit_in | input | 1 | Asynchronous inhibit pin; its falling edge counts while count_in is high |
| lamp_test | input | 1 | Forces all segments on |
| rb_in | input | 1 | Blanking input, low enables zero suppression |
| seg | output | 7 | Segments a (bit 0) to g (bit 6), active high |
| carry_out | output | 1 | High for digits 0 to 4, low for 5 to 9 |
| rb_out | output | 1 | Low when this digit is a suppressed zero |

## Verification
A wrong Johnson state shows up at the ports right away: the segment pattern and the carry level are both decoded combinationally from the state register, with no extra stage between them. A missed or doubled advance appears on `seg` at the third clock edge after the pin change. A wrong value would also persist, because every later digit in the walk is offset from the expected one. An error in the blanking or lamp-test logic is visible on `seg` and `rb_out` in the same cycle the inputs settle.

// File: rtl/decade_pkg.sv
package decade_pkg;
    localparam int JW    = 5;
    localparam int SEG_W = 7;

    typedef enum logic [JW-1:0] {
        D0 = 5'b00000,
        D1 = 5'b00001,
        D2 = 5'b00011,
        D3 = 5'b00111,
        D4 = 5'b01111,
        D5 = 5'b11111,
        D6 = 5'b11110,
        D7 = 5'b11100,
        D8 = 5'b11000,
        D9 = 5'b10000
    } jstate_t;

    localparam logic [SEG_W-1:0] SEG_ALL = '1;
    localparam logic [SEG_W-1:0] SEG_OFF = '0;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    localparam int TOP = STAGES;

    logic [TOP:0] sh;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) sh <= '0;
        else     sh <= {sh[TOP-1:0], din};
    end

    always_comb begin
        level = sh[TOP-1];
        rise  = sh[TOP-1] & ~sh[TOP];
        fall  = ~sh[TOP-1] & sh[TOP];
    end

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/johnson_ctr.sv
module johnson_ctr
    import decade_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    adv,
    output jstate_t state,
    output logic    carry
);
    jstate_t nxt;
    logic [JW-1:0] bits;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)      state <= D0;
        else if (adv) state <= nxt;
    end

    always_comb begin
        unique case (state)
            D0: nxt = D1;
            D1: nxt = D2;
            D2: nxt = D3;
            D3: nxt = D4;
            D4: nxt = D5;
            D5: nxt = D6;
            D6: nxt = D7;
            D7: nxt = D8;
            D8: nxt = D9;
            D9: nxt = D0;
            default: nxt = D0;
        endcase
    end

    always_comb begin
        bits  = state;
        carry = ~bits[JW-1];
    end

    // R3
    advance_moves_chk: assert property (@(posedge clk) disable iff (rst)
        adv |=> state != $past(state));
    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> state == $past(state));
    // R6
    carry_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(carry) |-> ($past(state) == D9 && state == D0));
endmodule

// File: rtl/seg_decode.sv
module seg_decode
    import decade_pkg::*;
(
    input  jstate_t          state,
    input  logic             lamp,
    input  logic             rb_in,
    output logic [SEG_W-1:0] seg,
    output logic             rb_out
);
    logic [SEG_W-1:0] pat;
    logic             blank;

    always_comb begin
        unique case (state)
            D0: pat = 7'h3F;
            D1: pat = 7'h06;
            D2: pat = 7'h5B;
            D3: pat = 7'h4F;
            D4: pat = 7'h66;
            D5: pat = 7'h6D;
            D6: pat = 7'h7D;
            D7: pat = 7'h07;
            D8: pat = 7'h7F;
            D9: pat = 7'h6F;
            default: pat = SEG_OFF;
        endcase
    end

    always_comb begin
        blank  = ~rb_in & (state == D0);
        rb_out = ~blank;
        if (lamp)       seg = SEG_ALL;
        else if (blank) seg = SEG_OFF;
        else            seg = pat;
    end
endmodule

// File: rtl/decade_display.sv
module decade_display
    import decade_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             count_in,
    input  logic             inhibit_in,
    input  logic             lamp_test,
    input  logic             rb_in,
    output logic [SEG_W-1:0] seg,
    output logic             carry_out,
    output logic             rb_out
);
    logic    cnt_lvl, cnt_rise, cnt_fall;
    logic    inh_lvl, inh_rise, inh_fall;
    logic    adv;
    jstate_t state;

    edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk(clk), .rst(rst), .din(count_in),
        .level(cnt_lvl), .rise(cnt_rise), .fall(cnt_fall)
    );

    edge_sync #(.STAGES(SYNC_STAGES)) u_inh_sync (
        .clk(clk), .rst(rst), .din(inhibit_in),
        .level(inh_lvl), .rise(inh_rise), .fall(inh_fall)
    );

    always_comb begin
        adv = (cnt_rise & ~inh_lvl) | (inh_fall & cnt_lvl);
    end

    johnson_ctr u_ctr (
        .clk(clk), .rst(rst), .adv(adv), .state(state), .carry(carry_out)
    );

    seg_decode u_dec (
        .state(state), .lamp(lamp_test), .rb_in(rb_in),
        .seg(seg), .rb_out(rb_out)
    );

    // R4
    inhibit_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (inh_lvl && !inh_fall) |=> $stable(state));
    // R8
    lamp_all_on_chk: assert property (@(posedge clk) disable iff (rst)
        lamp_test |-> seg == SEG_ALL);
    // R9
    blank_rule_chk: assert property (@(posedge clk) disable iff (rst)
        (!rb_out && !lamp_test) |-> (seg == SEG_OFF && state == D0));
    // R5
    unused_edges_chk: assert property (@(posedge clk) disable iff (rst)
        (inh_rise || cnt_fall) && !cnt_rise && !inh_fall |=> $stable(state));
endmodule

// File: tb/decade_display_test.sv
`timescale 1ns/1ps
module decade_display_test;
    typedef struct {
        logic [6:0] seg;
        logic       carry;
        logic       rbo;
        string      tag;
    } exp_t;

    logic       clk = 0;
    logic       rst = 1;
    logic       count_in = 0, inhibit_in = 0, lamp_test = 0, rb_in = 1;
    logic [6:0] seg;
    logic       carry_out, rb_out;

    int   total = 0, bad = 0, exp_cnt = 0;
    bit   finished = 0;
    exp_t sb[$];
    exp_t cur;

    decade_display uut (
        .clk(clk), .rst(rst), .count_in(count_in), .inhibit_in(inhibit_in),
        .lamp_test(lamp_test), .rb_in(rb_in), .seg(seg),
        .carry_out(carry_out), .rb_out(rb_out)
    );

    always #5 clk = ~clk;

    function automatic logic [6:0] digit_pat(int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; default: return 7'h6F;
        endcase
    endfunction

    task automatic push(string tag);
        exp_t e;
        e.rbo   = !(exp_cnt == 0 && !rb_in);
        e.carry = (exp_cnt < 5);
        e.seg   = lamp_test ? 7'h7F : (!e.rbo ? 7'h00 : digit_pat(exp_cnt));
        e.tag   = tag;
        sb.push_back(e);
    endtask

    task automatic check(string tag);
        push(tag);
        @(negedge clk); #1;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
    endtask

    task automatic pulse_count();
        count_in = 1; settle();
        count_in = 0; settle();
    endtask

    always @(negedge clk) begin
        if (sb.size() != 0) begin
            cur = sb.pop_front();
            total++;
            if (seg !== cur.seg || carry_out !== cur.carry || rb_out !== cur.rbo) begin
                bad++;
                $display("FAIL %s: seg=%h carry=%b rbo=%b expected seg=%h carry=%b rbo=%b",
                         cur.tag, seg, carry_out, rb_out, cur.seg, cur.carry, cur.rbo);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check("R2 during reset");
        count_in = 1; settle(); count_in = 0;
        check("R2 reset beats count");
        rst = 0; settle();
        check("R2 after reset");

        // R3 R7 R6 R1: walk all ten digits
        for (int i = 0; i < 10; i++) begin
            pulse_count();
            exp_cnt = (exp_cnt + 1) % 10;
            check($sformatf("R3/R7/R6 digit %0d", exp_cnt));
        end
        check("R1 back to zero after ten");

        // R4: inhibit blocks count edges
        pulse_count(); exp_cnt = 1; check("R3 advance to 1");
        inhibit_in = 1; settle();
        for (int i = 0; i < 3; i++) pulse_count();
        check("R4 inhibited edges ignored");

        // R5: inhibit falling edge counts with count held high
        count_in = 1; settle();
        check("R5 count rise under inhibit ignored");
        inhibit_in = 0; settle(); exp_cnt = 2;
        check("R5 inhibit fall advances");
        inhibit_in = 1; settle();
        check("R5 inhibit rise no advance");
        count_in = 0; settle();
        check("R5 count fall no advance");
        inhibit_in = 0; settle();
        check("R5 inhibit fall with count low no advance");

        // R10: latency and single advance for held level
        @(negedge clk); #1;
        count_in = 1;
        @(posedge clk); @(posedge clk);
        check("R10 not yet after two edges");
        @(posedge clk); exp_cnt = 3;
        check("R10 visible after third edge");
        repeat (20) @(posedge clk);
        check("R10 held level one advance");
        count_in = 0; settle();

        // R8: lamp test
        lamp_test = 1; settle();
        check("R8 lamp on");
        lamp_test = 0; settle();
        check("R8 digit kept after lamp");

        // R9: blanking
        rst = 1; settle(); rst = 0; exp_cnt = 0; settle();
        rb_in = 0; settle();
        check("R9 zero blanked");
        lamp_test = 1; settle();
        check("R8 lamp overrides blanking");
        lamp_test = 0; settle();
        pulse_count(); exp_cnt = 1;
        check("R9 nonzero shown with rb_in low");
        for (int i = 0; i < 9; i++) pulse_count();
        exp_cnt = 0;
        check("R9 blank again on wrap, R6 carry high");
        rb_in = 1; settle();
        check("R9 zero shown with rb_in high");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule